// File: doc/BRIEF.md
# Dual-Port Programmable Parallel I/O Adapter

This block places two 8-bit parallel ports, A and B, on a simple host bus. Each port owns a direction register, an output data register and a control register, so six registers are reached through four host addresses. Bit 2 of a port's control register chooses whether that port's first address reaches its direction register or its data register. The host sets each line of a port as an input or an output. It writes the levels that output lines drive and reads back a mix of driven and sampled levels. Pads are modelled with separate output and output-enable vectors.

Each port has one control input and one active-low control output. An edge of the selected polarity on the control input sets the port's interrupt flag. If the port's interrupt enable is set, the flag pulls that port's active-low interrupt output low. A read of the data register clears the flag. In pulse mode the control output goes low for one clock after each data-register access that marks a transfer: a write on port B, a read on port A. The control inputs pass through a two-stage synchronizer.

Top module: `dual_port_pio`

## Requirements
- R1: After reset all registers are 0. Every oe bit is 0, every out bit is 0, both interrupt outputs are high, both control outputs are high, and bus_rdata is 0.
- R2: bus_rs bit 1 selects the port (0 = A, 1 = B). bus_rs bit 0 = 1 selects that port's control register. bus_rs bit 0 = 0 selects the direction register when control bit 2 is 0, and the data register when control bit 2 is 1.
- R3: Each oe bit equals the matching direction bit (1 = output). Each out bit equals the matching data-register bit. Both follow the write edge.
- R4: A data-register read returns the data-register bit for output lines and the port input level for input lines. The value is sampled at the access edge and appears on bus_rdata after that edge.
- R5: Control bit 1 selects the edge polarity of the control input: 0 = high-to-low, 1 = low-to-high. An edge of the selected polarity sets the flag in control bit 7 three clock edges after the input changes.
- R6: A port's interrupt output is low exactly when its flag and its control bit 0 (interrupt enable) are both 1.
- R7: A read of a port's data register clears its flag. A read of its direction register does not. When an edge and a clearing read fall on the same clock edge, the flag stays set.
- R8: With control bit 3 (pulse mode) set, a write to port B's data register or a read of port A's data register drives that port's control output low for exactly one clock. With bit 3 clear the control output stays high.
- R9: Control bit 7 is read-only, so writes to it are ignored. Control bits 6:4 always read as 0.
- R10: With bus_sel low, no register changes and bus_rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the bus-enable timing reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Chip select; one access per clock while high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| a_in | input | 8 | Port A pad input levels |
| a_out | output | 8 | Port A pad output levels |
| a_oe | output | 8 | Port A pad output enables |
| a_ctl1 | input | 1 | Port A control input (interrupt source) |
| a_ctl2_n | output | 1 | Port A active-low control output |
| a_irq_n | output | 1 | Port A active-low interrupt |
| b_in | input | 8 | Port B pad input levels |
| b_out | output | 8 | Port B pad output levels |
| b_oe | output | 8 | Port B pad output enables |
| b_ctl1 | input | 1 | Port B control input (interrupt source) |
| b_ctl2_n | output | 1 | Port B active-low control output |
| b_irq_n | output | 1 | Port B active-low interrupt |

## Verification
The random phase mixes direction masks and data values, so a readback that takes all lines from the pad can be told apart from one that takes all lines from the register. The random phase also flips the select bit in control bit 2 between accesses, which shows up a decoder that ignores the bit. Directed cases cover both edge polarities and an edge that arrives in the same cycle as a clearing read. They also drive a write with select low, and check that a single write yields a one-clock pulse and not a held level.

// File: rtl/pio_pkg.sv
// Shared widths and the control-register layout for the parallel I/O adapter.
// Assumes an 8-bit host data bus and 8-bit ports.
package pio_pkg;
    localparam int DATA_W = 8;
    localparam int RS_W   = 2;
    localparam int NPORTS = 2;
    localparam int SYNC_STAGES = 2;

    // Control register, bit 7 down to bit 0.
    typedef struct packed {
        logic       flag;      // 7: interrupt flag, read-only
        logic [2:0] rsvd;      // 6:4: read as zero
        logic       pulse_en;  // 3: one-clock strobe on transfer access
        logic       data_sel;  // 2: 1 = data register, 0 = direction register
        logic       rise_sel;  // 1: 1 = rising edge, 0 = falling edge
        logic       irq_en;    // 0: drive the interrupt output from the flag
    } ctrl_t;
endpackage

// File: rtl/pio_edge_sync.sv
// Synchronizes an asynchronous control input and flags a single-cycle edge
// of the selected polarity. Assumes the input is held for at least two clocks.
module pio_edge_sync #(
    parameter int STAGES = pio_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic rise_sel,
    output logic hit
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchronizer and keep the last settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Compare the settled level with the previous one for the chosen polarity.
    always_comb begin
        if (rise_sel) hit = sync_q[STAGES-1] & ~prev_q;
        else          hit = ~sync_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/pio_port.sv
// One port: direction, data and control registers, the interrupt flag and the
// pulse-mode strobe. The parent decodes the address; this module sees one
// access strobe per register class. PULSE_ON_WRITE picks whether the strobe
// follows a data write (1) or a data read (0).
module pio_port #(
    parameter int W = pio_pkg::DATA_W,
    parameter bit PULSE_ON_WRITE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_dd,    // access to data/direction address
    input  logic         acc_ctrl,  // access to control address
    input  logic         rd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic         ctl1_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val,
    output logic         irq_n,
    output logic         ctl2_n
);
    import pio_pkg::*;

    logic [W-1:0] dir_q;
    logic [W-1:0] dat_q;
    ctrl_t        ctrl_q;
    logic         edge_hit;
    logic         data_rd;
    logic         data_wr;
    logic         dir_wr;
    logic         xfer;

    pio_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ctl1_in),
        .rise_sel(ctrl_q.rise_sel),
        .hit     (edge_hit)
    );

    // Split the shared address into data and direction accesses.
    always_comb begin
        data_rd = acc_dd & rd & ctrl_q.data_sel;
        data_wr = acc_dd & ~rd & ctrl_q.data_sel;
        dir_wr  = acc_dd & ~rd & ~ctrl_q.data_sel;
        xfer    = PULSE_ON_WRITE ? data_wr : data_rd;
    end

    // Hold the direction and output data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else begin
            if (dir_wr)  dir_q <= wdata;
            if (data_wr) dat_q <= wdata;
        end
    end

    // Hold the writable control fields; the flag and reserved bits are excluded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.pulse_en <= 1'b0;
            ctrl_q.data_sel <= 1'b0;
            ctrl_q.rise_sel <= 1'b0;
            ctrl_q.irq_en   <= 1'b0;
        end else if (acc_ctrl && !rd) begin
            ctrl_q.pulse_en <= wdata[3];
            ctrl_q.data_sel <= wdata[2];
            ctrl_q.rise_sel <= wdata[1];
            ctrl_q.irq_en   <= wdata[0];
        end
    end

    // Reserved control bits are fixed at zero.
    always_comb ctrl_q.rsvd = 3'b000;

    // Set the flag on an edge, clear it on a data read; the edge wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q.flag <= 1'b0;
        else if (edge_hit) ctrl_q.flag <= 1'b1;
        else if (data_rd)  ctrl_q.flag <= 1'b0;
    end

    // Drive the strobe low for the clock that follows a transfer access.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl2_n <= 1'b1;
        else        ctl2_n <= ~(xfer & ctrl_q.pulse_en);
    end

    // Pad drive, interrupt and read-back selection.
    always_comb begin
        pin_out = dat_q;
        pin_oe  = dir_q;
        irq_n   = ~(ctrl_q.flag & ctrl_q.irq_en);
        if (acc_ctrl)             rd_val = W'(ctrl_q);
        else if (ctrl_q.data_sel) rd_val = (dat_q & dir_q) | (pin_in & ~dir_q);
        else                      rd_val = dir_q;
    end
endmodule

// File: rtl/dual_port_pio.sv
// Top of the parallel I/O adapter: decodes the 2-bit register select into
// per-port strobes, instantiates both ports and registers the read data.
// Assumes single-cycle host accesses, one per clock while bus_sel is high.
module dual_port_pio #(
    parameter int W = pio_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_rd,
    input  logic [1:0]   bus_rs,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic         a_ctl1,
    output logic         a_ctl2_n,
    output logic         a_irq_n,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         b_ctl1,
    output logic         b_ctl2_n,
    output logic         b_irq_n
);
    localparam int NP = pio_pkg::NPORTS;

    logic [W-1:0] p_in   [NP];
    logic [W-1:0] p_out  [NP];
    logic [W-1:0] p_oe   [NP];
    logic [W-1:0] p_rd   [NP];
    logic         p_ctl1 [NP];
    logic         p_ctl2 [NP];
    logic         p_irq  [NP];

    // Map the named pads onto the port arrays.
    always_comb begin
        p_in[0]   = a_in;
        p_in[1]   = b_in;
        p_ctl1[0] = a_ctl1;
        p_ctl1[1] = b_ctl1;
        a_out     = p_out[0];
        b_out     = p_out[1];
        a_oe      = p_oe[0];
        b_oe      = p_oe[1];
        a_ctl2_n  = p_ctl2[0];
        b_ctl2_n  = p_ctl2[1];
        a_irq_n   = p_irq[0];
        b_irq_n   = p_irq[1];
    end

    for (genvar g = 0; g < NP; g++) begin : g_port
        logic hit_port;
        assign hit_port = bus_sel && (bus_rs[1] == g[0]);
        pio_port #(
            .W             (W),
            .PULSE_ON_WRITE(g == 1)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_dd  (hit_port && !bus_rs[0]),
            .acc_ctrl(hit_port && bus_rs[0]),
            .rd      (bus_rd),
            .wdata   (bus_wdata),
            .pin_in  (p_in[g]),
            .ctl1_in (p_ctl1[g]),
            .pin_out (p_out[g]),
            .pin_oe  (p_oe[g]),
            .rd_val  (p_rd[g]),
            .irq_n   (p_irq[g]),
            .ctl2_n  (p_ctl2[g])
        );
    end

    // Capture the selected register on a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)                bus_rdata <= '0;
        else if (bus_sel && bus_rd) bus_rdata <= p_rd[bus_rs[1]];
    end
endmodule

// File: rtl/dual_port_pio_chk.sv
// Protocol checks for dual_port_pio, attached with bind.
module dual_port_pio_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_rd,
    input logic [1:0]   bus_rs,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_out,
    input logic         a_irq_n,
    input logic         b_ctl2_n
);
    assert_oe_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_rd) |-> $stable(a_oe));

    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel) |-> ($stable(b_out) && $stable(bus_rdata)));

    assert_pulse_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_ctl2_n) |=> b_ctl2_n);

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_ctl2_n) |-> $past(bus_sel && !bus_rd && bus_rs == 2'b10));

    assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_irq_n) |-> $past(bus_sel && ((bus_rd && bus_rs == 2'b00) ||
                                             (!bus_rd && bus_rs == 2'b01))));

    assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && bus_rd && bus_rs[0]) |-> (bus_rdata[6:4] == 3'b000));
endmodule

bind dual_port_pio dual_port_pio_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_rd   (bus_rd),
    .bus_rs   (bus_rs),
    .bus_rdata(bus_rdata),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .a_irq_n  (a_irq_n),
    .b_ctl2_n (b_ctl2_n)
);

// File: tb/dual_port_pio_test.sv
module dual_port_pio_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_rs = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic [7:0] a_out, a_oe, b_out, b_oe;
    logic       a_ctl1 = 1'b1, b_ctl1 = 1'b1;
    logic       a_ctl2_n, b_ctl2_n, a_irq_n, b_irq_n;

    int checks = 0;
    int fails  = 0;

    // bench model, index 0 = port A, 1 = port B
    logic [7:0] m_dir [2];
    logic [7:0] m_dat [2];
    logic [3:0] m_cr  [2];
    logic       m_flag[2];

    always #2 clk = ~clk;

    dual_port_pio uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_rs(bus_rs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_ctl1(a_ctl1),
        .a_ctl2_n(a_ctl2_n), .a_irq_n(a_irq_n),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .b_ctl1(b_ctl1),
        .b_ctl2_n(b_ctl2_n), .b_irq_n(b_irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pin_of(input int p);
        return p == 0 ? a_in : b_in;
    endfunction

    // expected read value from the model
    function automatic logic [7:0] exp_read(input int p, input bit ctl);
        if (ctl) return {m_flag[p], 3'b000, m_cr[p]};
        if (m_cr[p][2]) return (m_dat[p] & m_dir[p]) | (pin_of(p) & ~m_dir[p]);
        return m_dir[p];
    endfunction

    function automatic void model_write(input int p, input bit ctl, input logic [7:0] v);
        if (ctl) m_cr[p] = v[3:0];
        else if (m_cr[p][2]) m_dat[p] = v;
        else m_dir[p] = v;
    endfunction

    task automatic bus_write(input logic [1:0] rs, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b0; bus_rs = rs; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0;
        model_write(int'(rs[1]), rs[0], v);
    endtask

    task automatic bus_read(input logic [1:0] rs, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_rs = rs;
        @(negedge clk);
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // read with model check; a data read clears the flag in the model
    task automatic read_chk(input string req, input logic [1:0] rs);
        logic [7:0] e, v;
        int p = int'(rs[1]);
        e = exp_read(p, rs[0]);
        bus_read(rs, v);
        check(req, v, e);
        if (!rs[0] && m_cr[p][2]) m_flag[p] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd1234));
        for (int p = 0; p < 2; p++) begin
            m_dir[p] = 0; m_dat[p] = 0; m_cr[p] = 0; m_flag[p] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 a_oe", a_oe, 8'h00);
        check("R1 b_oe", b_oe, 8'h00);
        check("R1 b_out", b_out, 8'h00);
        check("R1 irq/strobe", {4'h0, a_irq_n, b_irq_n, a_ctl2_n, b_ctl2_n}, 8'h0F);
        check("R1 rdata", bus_rdata, 8'h00);

        // R2/R3 direction register behind address 0 while bit2 clear
        bus_write(2'b00, 8'hF0);
        check("R3 a_oe", a_oe, 8'hF0);
        read_chk("R2 dir A", 2'b00);
        bus_write(2'b01, 8'h04);
        bus_write(2'b00, 8'hA5);
        check("R3 a_out", a_out, 8'hA5);
        check("R2 dir kept", a_oe, 8'hF0);
        // R4 mixed read
        a_in = 8'h3C;
        read_chk("R4 data A", 2'b00);

        // R9 flag bit not writable, reserved zero
        bus_write(2'b01, 8'hF4);
        read_chk("R9 ctrl A", 2'b01);

        // R10 no access without select
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0; bus_rs = 2'b10; bus_wdata = 8'hFF;
        @(negedge clk);
        check("R10 b_out", b_out, 8'h00);
        read_chk("R10 dir B", 2'b10);

        // R5/R6 falling edge on port A with interrupt enabled
        bus_write(2'b01, 8'h05);
        @(negedge clk); a_ctl1 = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 irq not yet", {7'h0, a_irq_n}, 8'h01);
        @(negedge clk);
        m_flag[0] = 1'b1;
        check("R5 R6 irq_a low", {7'h0, a_irq_n}, 8'h00);
        read_chk("R5 flag bit7", 2'b01);
        // R7 direction read does not clear
        bus_write(2'b01, 8'h01);
        read_chk("R7 dir read", 2'b00);
        check("R7 irq held", {7'h0, a_irq_n}, 8'h00);
        bus_write(2'b01, 8'h05);
        read_chk("R7 data read", 2'b00);
        check("R7 irq released", {7'h0, a_irq_n}, 8'h01);

        // R5 rising polarity on port B, R7 edge and clear on the same edge
        bus_write(2'b11, 8'h07);
        b_ctl1 = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 rise ignores fall", {7'h0, b_irq_n}, 8'h01);
        b_ctl1 = 1'b1;
        @(negedge clk);
        bus_read(2'b10, v);
        m_flag[1] = 1'b1;
        read_chk("R7 edge wins", 2'b11);
        check("R6 irq_b low", {7'h0, b_irq_n}, 8'h00);
        read_chk("R7 clear B", 2'b10);
        check("R6 irq_b released", {7'h0, b_irq_n}, 8'h01);

        // R8 pulse mode on port B write
        bus_write(2'b11, 8'h0C);
        bus_write(2'b10, 8'h5A);
        check("R8 b strobe low", {7'h0, b_ctl2_n}, 8'h00);
        @(negedge clk);
        check("R8 b strobe one clock", {7'h0, b_ctl2_n}, 8'h01);
        // R8 pulse on port A data read
        bus_write(2'b01, 8'h0C);
        bus_read(2'b00, v);
        check("R8 a strobe low", {7'h0, a_ctl2_n}, 8'h00);
        @(negedge clk);
        check("R8 a strobe high", {7'h0, a_ctl2_n}, 8'h01);
        // R8 no pulse without bit3
        bus_write(2'b11, 8'h04);
        bus_write(2'b10, 8'h11);
        check("R8 b no strobe", {7'h0, b_ctl2_n}, 8'h01);

        // random register traffic, R2 R3 R4 R9
        for (int i = 0; i < 400; i++) begin
            logic [1:0] rs;
            logic [7:0] d;
            rs = 2'($urandom_range(0, 3));
            d  = 8'($urandom);
            a_in = 8'($urandom);
            b_in = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                if (rs[0]) d[3] = 1'b0;
                bus_write(rs, d);
                check("R3 a_oe random", a_oe, m_dir[0]);
                check("R3 b_out random", b_out, m_dat[1]);
            end else begin
                read_chk("R2 R4 random read", rs);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule